// File: doc/BRIEF.md
# I2C Register Access Target

This block is an I2C bus target that lets a bus master read and write a 256-entry, 8-bit internal register file. A system clock much faster than the bus clock oversamples the SCL and SDA lines. Each line passes through a two-flop synchronizer before its edges are found. The block drives SDA only through an open-drain output enable. When that enable is high the line is pulled low. When it is low the line is left to the pull-up.

The block answers only to the fixed 7-bit address 1000011. After that address, a write transaction sends a sub-address byte and then any number of data bytes. A read transaction returns bytes starting at an internal pointer. That pointer advances after every byte moved and keeps its value from one transaction to the next. This supports three kinds of read:
- a read at the current pointer;
- a random read, which is a write of the sub-address followed by a repeated START with the read bit set;
- a sequential read, which runs until the master answers NO ACK and then issues a STOP.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the SDA output enable is low, and it stays low until a START is followed by a matching address byte.
- R2: When the byte after a START carries the address 1000011 in its upper seven bits, the block pulls SDA low throughout the high phase of the 9th SCL pulse. This holds for both values of the direction bit, which is the LSB: 0 selects a write and 1 selects a read.
- R3: When the address does not match, SDA stays released during the 9th pulse. Every later byte is then ignored until the next START or STOP: none is acknowledged and none is stored.
- R4: In a write transaction, the byte after the address byte loads the sub-address pointer and is acknowledged. The next data byte is acknowledged and stored at that sub-address.
- R5: In a multibyte write, each further data byte is acknowledged and stored at the next sub-address. The sub-address wraps from 0xFF to 0x00.
- R6: A read that begins without setting a sub-address returns the byte at the pointer left by the previous transaction. That pointer is one past the last byte written or read.
- R7: A random read returns the byte at the sub-address that was sent before the repeated START.
- R8: A sequential read returns successive register bytes, MSB first, with the address wrapping modulo 256. After the master's NO ACK the block keeps SDA released.
- R9: The block changes its SDA drive only while SCL is low.
- R10: A STOP, which is SDA rising while SCL is high, ends the transaction. Bytes clocked after it without a new START are neither acknowledged nor stored.
- R11: A START, which is SDA falling while SCL is high, restarts address reception even in the middle of a byte. A partly received data byte is then discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | When high, pull SDA low (open-drain drive) |

## Verification
A wrong sequencer state appears on the bus within one byte time. It shows as a missing or extra acknowledge on the 9th pulse, or as a data bit driven at the wrong moment. A corrupted pointer or a lost write does not show until a later read returns the wrong byte. For that reason every write scenario is followed by random, current-address or sequential reads that cover the addresses involved. The read data is compared MSB first, and the acknowledge level is compared on every 9th pulse.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_i,
    output logic [N_LINES-1:0] lvl_o,
    output logic [N_LINES-1:0] rise_o,
    output logic [N_LINES-1:0] fall_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], line_i[g]};
        end
        assign lvl_o[g]  = pipe_q[STAGES-1];
        assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 8,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-2:0] DEV_ADDR  = 7'b1000011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BITS = CNT_W'(DATA_W);

    typedef struct packed {
        tgt_state_e        st;
        tgt_state_e        after;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              mack;
    } tgt_regs_t;

    tgt_regs_t d, q;

    logic [1:0] lvl, rise, fall;
    logic scl_lvl, scl_rise, scl_fall, sda_lvl, start, stop;
    logic we;
    logic [DATA_W-1:0] rdata;

    i2c_line_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_lvl  = lvl[0];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign sda_lvl  = lvl[1];
    assign start    = scl_lvl & fall[1];
    assign stop     = scl_lvl & rise[1];

    i2c_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (q.ptr),
        .wdata_i (q.sh),
        .raddr_i (q.ptr),
        .rdata_o (rdata)
    );

    always_comb begin
        d  = q;
        we = 1'b0;
        if (start) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DATA_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[DATA_W-1:1] == DEV_ADDR) begin
                                d.after = q.sh[0] ? ST_TX : ST_SUB;
                            end else begin
                                d.st = ST_IDLE;
                                d.oe = 1'b0;
                            end
                        end else if (q.st == ST_SUB) begin
                            d.ptr   = q.sh[ADDR_W-1:0];
                            d.after = ST_WDATA;
                        end else begin
                            we      = 1'b1;
                            d.ptr   = q.ptr + 1'b1;
                            d.after = ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.after == ST_TX) begin
                            d.sh  = rdata;
                            d.oe  = ~rdata[DATA_W-1];
                            d.ptr = q.ptr + 1'b1;
                            d.cnt = '0;
                            d.st  = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = q.after;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS - 1'b1) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh  = q.sh << 1;
                            d.oe  = ~q.sh[DATA_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh  = rdata;
                            d.oe  = ~rdata[DATA_W-1];
                            d.ptr = q.ptr + 1'b1;
                            d.cnt = '0;
                            d.st  = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, after: ST_IDLE, cnt: '0, sh: '0,
                   ptr: '0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-2:0] DEV_ADDR = 7'b1000011
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start,
    input logic              stop,
    input logic              we,
    input tgt_state_e        st,
    input logic [DATA_W-1:0] sh,
    input logic [ADDR_W-1:0] ptr,
    input logic              sda_oe
);
    assert_ack_only_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && $past(st) == ST_ADDR) |-> $past(sh[DATA_W-1:1]) == DEV_ADDR);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ptr == $past(ptr) + 1'b1);

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe) && !$past(start || stop)) |-> !scl_lvl);

    assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe);

    assert_restart_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st == ST_ADDR && !sda_oe && !we));
endmodule

bind i2c_reg_target i2c_tgt_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_lvl),
    .start   (start),
    .stop    (stop),
    .we      (we),
    .st      (q.st),
    .sh      (q.sh),
    .ptr     (q.ptr),
    .sda_oe  (sda_oe_o)
);

// File: tb/test_i2c_reg_target.sv
`timescale 1ns/1ps
module test_i2c_reg_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_viol = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    i2c_reg_target i_i2c_reg_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n && scl_drv && scl_prev && sda_oe !== oe_prev) n_viol++;
        scl_prev = scl_drv;
        oe_prev  = sda_oe;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #2;
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq();
        scl_drv = 1'b1; wq();
        m_low = 1'b1; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        scl_drv = 1'b1; wq();
        m_low = 1'b0; wq();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; wq();
        scl_drv = 1'b1; wq(); wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; wq();
        scl_drv = 1'b1; wq();
        b = sda_bus; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic rand_read1(input logic [7:0] sub, output logic [7:0] v);
        logic a;
        bus_start();
        put_byte(8'h86, a);
        put_byte(sub, a);
        bus_start();
        put_byte(8'h87, a);
        get_byte(v, 1'b0);
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1 oe after reset", int'(sda_oe), 0);
    endtask

    task automatic t_single_write();
        logic a;
        bus_start();
        put_byte(8'h86, a); check(a, "R2 write address ack", int'(a), 1);
        put_byte(8'h10, a); check(a, "R4 sub-address ack", int'(a), 1);
        put_byte(8'hA5, a); check(a, "R4 data ack", int'(a), 1);
        bus_stop();
    endtask

    task automatic t_multi_write();
        logic a;
        logic [7:0] vals [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        bus_start();
        put_byte(8'h86, a);
        put_byte(8'hFE, a);
        for (int i = 0; i < 4; i++) begin
            put_byte(vals[i], a);
            check(a, "R5 multibyte ack", int'(a), 1);
        end
        bus_stop();
    endtask

    task automatic t_seq_read();
        logic a;
        logic [7:0] v;
        logic [7:0] exp [3] = '{8'h11, 8'h22, 8'h33};
        bus_start();
        put_byte(8'h86, a);
        put_byte(8'hFE, a);
        bus_start();
        put_byte(8'h87, a); check(a, "R2 read address ack", int'(a), 1);
        for (int i = 0; i < 3; i++) begin
            get_byte(v, i != 2);
            check(v == exp[i], "R8 sequential data with wrap", int'(v), int'(exp[i]));
        end
        check(sda_oe == 1'b0, "R8 released after NO ACK", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'h87, a);
        get_byte(v, 1'b0);
        bus_stop();
        check(v == 8'h44, "R6 current-address read", int'(v), 8'h44);
    endtask

    task automatic t_random_read();
        logic [7:0] v;
        rand_read1(8'h10, v);
        check(v == 8'hA5, "R7 random read", int'(v), 8'hA5);
        rand_read1(8'h00, v);
        check(v == 8'h33, "R5 wrapped write at 0x00", int'(v), 8'h33);
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'h42, a); check(!a, "R3 mismatch not acked", int'(a), 0);
        put_byte(8'h10, a); check(!a, "R3 later byte ignored", int'(a), 0);
        put_byte(8'h5A, a); check(!a, "R3 later data ignored", int'(a), 0);
        bus_stop();
        rand_read1(8'h10, v);
        check(v == 8'hA5, "R3 register untouched", int'(v), 8'hA5);
    endtask

    task automatic t_stop_ends();
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'h86, a);
        put_byte(8'h20, a);
        put_byte(8'h77, a);
        bus_stop();
        scl_drv = 1'b0; wq();
        put_byte(8'h99, a); check(!a, "R10 byte after STOP not acked", int'(a), 0);
        bus_stop();
        rand_read1(8'h20, v);
        check(v == 8'h77, "R10 last data before STOP kept", int'(v), 8'h77);
        rand_read1(8'h21, v);
        check(v == 8'h00, "R10 byte after STOP not stored", int'(v), 0);
    endtask

    task automatic t_restart_mid_byte();
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'h86, a);
        put_byte(8'h30, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'h86, a); check(a, "R11 address after restart acked", int'(a), 1);
        put_byte(8'h31, a);
        put_byte(8'h5C, a);
        bus_stop();
        rand_read1(8'h30, v);
        check(v == 8'h00, "R11 partial byte discarded", int'(v), 0);
        rand_read1(8'h31, v);
        check(v == 8'h5C, "R11 write after restart", int'(v), 8'h5C);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(posedge clk);
                #2 rst_n = 1'b1;
                wq();
                t_reset();
                t_single_write();
                t_multi_write();
                t_seq_read();
                t_current_read();
                t_random_read();
                t_mismatch();
                t_stop_ends();
                t_restart_mid_byte();
                check(n_viol == 0, "R9 drive changes with SCL high", n_viol, 0);
            end
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule